// File: doc/BRIEF.md
# Fractional-N Audio Master Clock Divider

This block produces an audio master clock from a faster source clock. The division ratio is an integer N plus a fraction b/a. The block has no accumulator. Instead it plays a fixed, register-encoded pattern of short periods (N source cycles) and long periods (N+1 source cycles). Over one pattern frame there are a output periods, and b of them are long. The average output frequency is therefore f_src / (N + b/a).

Software loads five values into a shadow bank with a write strobe:

- the integer divisor N;
- a repeat count X;
- a tail count Y;
- a group count Z;
- a majority-select bit that says which period length is the rare one.

A separate update strobe stages the shadow bank. The staged set takes effect at the next frame boundary, so no period is ever cut short.

The block has three outputs:

- a one-cycle enable at the start of each output period;
- a clock-shaped output that is high for the first half of each period;
- a one-cycle flag on the final source cycle of each frame.

Top module: `frac_mclk_div`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, `mclk_en` and `mclk_out` are 1 and `frame_done` is 0. After reset the active divisor is 4 with the fraction off.
- R2: If the active X or Z is 0, the fraction is off. Every period then lasts exactly N source cycles, and each period forms a frame of its own.
- R3: With majority-select 0, a frame is Z groups followed by Y periods of N cycles. Each group is X periods of N cycles followed by one period of N+1.
- R4: With majority-select 1, a frame is Z groups followed by Y periods of N+1 cycles. Each group is one period of N cycles followed by X periods of N+1.
- R5: A frame spans a·N+b source cycles and holds a enable pulses. In majority-select 0, a = Z(X+1)+Y and b = Z. In majority-select 1, a = Z(X+1)+Y and b = a−Z. With N=6, X=1, Y=2, Z=47 and majority-select 1, a frame is 625 cycles holding 96 periods, which gives 24.576 MHz from a 160 MHz source.
- R6: In every period of length L, `mclk_out` is high for the first floor(L/2) source cycles and low for the rest.
- R7: Values written with `cfg_wr` have no effect on the outputs until `cfg_upd` is pulsed.
- R8: After `cfg_upd`, the current frame completes with the old settings. The new settings govern from the next frame onwards.
- R9: An active N below 2 is treated as 2.
- R10: `frame_done` is high for exactly one cycle per frame, on the last source cycle of that frame's last period. `mclk_en` follows in the next cycle.
- R11: With Y = 0 the frame has no tail and ends after the Z-th group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load the five configuration inputs into the shadow bank |
| cfg_div_n | input | W_N | Integer divisor N |
| cfg_rep_x | input | W_X | Repeat count X inside a group |
| cfg_tail_y | input | W_Y | Tail period count Y |
| cfg_grp_z | input | W_Z | Group count Z |
| cfg_long_maj | input | 1 | 0: long periods are the minority; 1: long periods are the majority |
| cfg_upd | input | 1 | Stage the shadow bank for the next frame boundary |
| mclk_en | output | 1 | One-cycle pulse at the start of each output period |
| mclk_out | output | 1 | Divided clock, high for the first half of each period |
| frame_done | output | 1 | One-cycle pulse on the last source cycle of each frame |

## Verification
The bench builds the block with its default widths: an 8-bit divisor, a 6-bit repeat count and 8-bit tail and group counts. Reset loads the fraction-off setting with a divisor of 4. These widths are enough to run the 96-period, 625-cycle frame of the 24.576 MHz setting in full. They also allow divisors 0 and 1 to be written, which exercises the clamp to 2. A short frame of ten periods lets an update land in the middle of a frame and be seen waiting for the boundary. A tailless frame with the majority bit set covers the case where Y is zero.

// File: rtl/fmd_pkg.sv
package fmd_pkg;

  // Which period length forms the majority of the pattern.
  typedef enum logic {
    MAJ_SHORT = 1'b0,
    MAJ_LONG  = 1'b1
  } fmd_maj_e;

  // Position of the sequencer inside a pattern frame.
  typedef enum logic {
    PH_GROUP = 1'b0,
    PH_TAIL  = 1'b1
  } fmd_phase_e;

endpackage

// File: rtl/fmd_cfg_bank.sv
module fmd_cfg_bank #(
  parameter int          CW      = 31,
  parameter logic [CW-1:0] RST_VEC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          upd,
  input  logic          boundary,
  input  logic [CW-1:0] cfg_in,
  output logic [CW-1:0] act
);

  logic [CW-1:0] sh_q, sh_d;
  logic [CW-1:0] st_q, st_d;
  logic [CW-1:0] act_q, act_d;
  logic          pend_q, pend_d;
  logic          commit;

  always_comb begin
    commit = boundary && pend_q;
    sh_d   = wr     ? cfg_in : sh_q;
    st_d   = upd    ? sh_q   : st_q;
    act_d  = commit ? st_q   : act_q;
    if (upd) begin
      pend_d = 1'b1;
    end else if (commit) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= RST_VEC;
      st_q   <= RST_VEC;
      act_q  <= RST_VEC;
      pend_q <= 1'b0;
    end else begin
      if (wr)     sh_q  <= sh_d;
      if (upd)    st_q  <= st_d;
      if (commit) act_q <= act_d;
      pend_q <= pend_d;
    end
  end

  assign act = act_q;

  // R8: the active set only moves right after a frame boundary
  assert_commit_at_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> $past(boundary));

  // R7: a pending update only appears after an update strobe
  assert_pend_from_upd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(upd));

endmodule

// File: rtl/fmd_pattern_seq.sv
module fmd_pattern_seq
  import fmd_pkg::*;
#(
  parameter int W_X = 6,
  parameter int W_Y = 8,
  parameter int W_Z = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic [W_X-1:0] x,
  input  logic [W_Y-1:0] y,
  input  logic [W_Z-1:0] z,
  input  fmd_maj_e       maj,
  output logic           long_per,
  output logic           last_per
);

  fmd_phase_e     ph_q, ph_d;
  logic [W_Z-1:0] grp_q, grp_d;
  logic [W_X-1:0] pos_q, pos_d;
  logic [W_Y-1:0] tl_q, tl_d;
  logic           frac_off;
  logic           grp_end;
  logic           grp_final;

  always_comb begin
    frac_off  = (x == '0) || (z == '0);
    grp_end   = (pos_q == x);
    grp_final = (grp_q == z - 1'b1);

    if (frac_off) begin
      long_per = 1'b0;
      last_per = 1'b1;
    end else if (ph_q == PH_GROUP) begin
      long_per = (maj == MAJ_LONG) ? (pos_q != '0) : grp_end;
      last_per = grp_end && grp_final && (y == '0);
    end else begin
      long_per = (maj == MAJ_LONG);
      last_per = (tl_q == y - 1'b1);
    end

    ph_d  = ph_q;
    grp_d = grp_q;
    pos_d = pos_q;
    tl_d  = tl_q;
    if (adv) begin
      if (last_per) begin
        ph_d  = PH_GROUP;
        grp_d = '0;
        pos_d = '0;
        tl_d  = '0;
      end else if (ph_q == PH_GROUP) begin
        if (grp_end) begin
          pos_d = '0;
          if (grp_final) begin
            ph_d = PH_TAIL;
            tl_d = '0;
          end else begin
            grp_d = grp_q + 1'b1;
          end
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end else begin
        tl_d = tl_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_GROUP;
      grp_q <= '0;
      pos_q <= '0;
      tl_q  <= '0;
    end else if (adv) begin
      ph_q  <= ph_d;
      grp_q <= grp_d;
      pos_q <= pos_d;
      tl_q  <= tl_d;
    end
  end

  // R11: the tail phase is never entered when the tail count is zero
  assert_tail_needs_y_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_TAIL) |-> (y != '0));

  // R3: a group position never runs past the repeat count
  assert_pos_in_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!frac_off && ph_q == PH_GROUP) |-> (pos_q <= x));

endmodule

// File: rtl/fmd_period_gen.sv
module fmd_period_gen #(
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] len,
  output logic          tick,
  output logic          hi,
  output logic          last
);

  logic [LW-1:0] cnt_q, cnt_d;

  always_comb begin
    last  = (cnt_q >= len - 1'b1);
    cnt_d = last ? '0 : cnt_q + 1'b1;
    tick  = (cnt_q == '0);
    hi    = (cnt_q < (len >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R6: each period opens in its high half
  assert_open_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> hi);

  // R9: no period is shorter than two source cycles
  assert_min_two_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/frac_mclk_div.sv
module frac_mclk_div
  import fmd_pkg::*;
#(
  parameter int          W_N          = 8,
  parameter int          W_X          = 6,
  parameter int          W_Y          = 8,
  parameter int          W_Z          = 8,
  parameter logic [W_N-1:0] RST_DIV_N = W_N'(4),
  parameter logic [W_X-1:0] RST_REP_X = '0,
  parameter logic [W_Y-1:0] RST_TAIL_Y = '0,
  parameter logic [W_Z-1:0] RST_GRP_Z = '0,
  parameter logic        RST_LONG_MAJ = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [W_N-1:0] cfg_div_n,
  input  logic [W_X-1:0] cfg_rep_x,
  input  logic [W_Y-1:0] cfg_tail_y,
  input  logic [W_Z-1:0] cfg_grp_z,
  input  logic           cfg_long_maj,
  input  logic           cfg_upd,
  output logic           mclk_en,
  output logic           mclk_out,
  output logic           frame_done
);

  localparam int CW = W_N + W_X + W_Y + W_Z + 1;
  localparam int LW = W_N + 1;
  localparam logic [CW-1:0] RST_VEC =
    {RST_DIV_N, RST_REP_X, RST_TAIL_Y, RST_GRP_Z, RST_LONG_MAJ};

  logic [CW-1:0]  act;
  logic [W_N-1:0] a_n;
  logic [W_X-1:0] a_x;
  logic [W_Y-1:0] a_y;
  logic [W_Z-1:0] a_z;
  logic           a_maj;
  logic [W_N-1:0] eff_n;
  logic [LW-1:0]  per_len;
  logic           long_per, last_per, per_end;

  fmd_cfg_bank #(.CW(CW), .RST_VEC(RST_VEC)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_wr),
    .upd      (cfg_upd),
    .boundary (frame_done),
    .cfg_in   ({cfg_div_n, cfg_rep_x, cfg_tail_y, cfg_grp_z, cfg_long_maj}),
    .act      (act)
  );

  assign {a_n, a_x, a_y, a_z, a_maj} = act;

  always_comb begin
    eff_n   = (a_n < W_N'(2)) ? W_N'(2) : a_n;
    per_len = {1'b0, eff_n} + LW'(long_per);
  end

  fmd_pattern_seq #(.W_X(W_X), .W_Y(W_Y), .W_Z(W_Z)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (per_end),
    .x        (a_x),
    .y        (a_y),
    .z        (a_z),
    .maj      (fmd_maj_e'(a_maj)),
    .long_per (long_per),
    .last_per (last_per)
  );

  fmd_period_gen #(.LW(LW)) u_per (
    .clk   (clk),
    .rst_n (rst_n),
    .len   (per_len),
    .tick  (mclk_en),
    .hi    (mclk_out),
    .last  (per_end)
  );

  assign frame_done = per_end && last_per;

  // R10: a new period starts right after every frame end
  assert_frame_then_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> mclk_en);

  // R10: the frame flag never lasts two cycles
  assert_frame_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

endmodule

// File: tb/test_frac_mclk_div.sv
`timescale 1ns/1ps
module test_frac_mclk_div;
  localparam int W_N = 8, W_X = 6, W_Y = 8, W_Z = 8;
  localparam int LOGN = 256;

  logic clk, rst_n, cfg_wr, cfg_upd, cfg_long_maj;
  logic [W_N-1:0] cfg_div_n;
  logic [W_X-1:0] cfg_rep_x;
  logic [W_Y-1:0] cfg_tail_y;
  logic [W_Z-1:0] cfg_grp_z;
  logic mclk_en, mclk_out, frame_done;

  int checks = 0, errors = 0;
  int len_log [LOGN];
  int hi_log  [LOGN];
  int fd_log  [LOGN];
  int n_per;
  bit cap_on, cap_started, prev_fd;
  int cur_len, cur_hi, cur_fd;
  int exp_len [LOGN];
  int exp_fd  [LOGN];
  int exp_cnt;

  frac_mclk_div i_frac_mclk_div (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_div_n(cfg_div_n),
    .cfg_rep_x(cfg_rep_x), .cfg_tail_y(cfg_tail_y), .cfg_grp_z(cfg_grp_z),
    .cfg_long_maj(cfg_long_maj), .cfg_upd(cfg_upd),
    .mclk_en(mclk_en), .mclk_out(mclk_out), .frame_done(frame_done)
  );

  initial begin clk = 1'b0; forever #4 clk = ~clk; end

  // Period logger, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n && cap_on) begin
      if (mclk_en && (cap_started || prev_fd)) begin
        if (cap_started && n_per < LOGN) begin
          len_log[n_per] = cur_len;
          hi_log[n_per]  = cur_hi;
          fd_log[n_per]  = cur_fd;
          n_per++;
        end
        cap_started = 1'b1;
        cur_len = 1;
        cur_hi  = mclk_out ? 1 : 0;
        cur_fd  = frame_done ? 1 : 0;
      end else if (cap_started) begin
        cur_len++;
        cur_hi += mclk_out ? 1 : 0;
        cur_fd += frame_done ? 1 : 0;
      end
    end
    if (rst_n) prev_fd = frame_done;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input int n, input int x, input int y, input int z, input bit lm);
    @(posedge clk); #1;
    cfg_div_n = W_N'(n); cfg_rep_x = W_X'(x); cfg_tail_y = W_Y'(y);
    cfg_grp_z = W_Z'(z); cfg_long_maj = lm; cfg_wr = 1'b1;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_upd();
    @(posedge clk); #1; cfg_upd = 1'b1;
    @(posedge clk); #1; cfg_upd = 1'b0;
  endtask

  task automatic arm_next_frame();
    do @(negedge clk); while (!frame_done);
    #1;
    cap_on = 1'b1; cap_started = 1'b0; n_per = 0;
  endtask

  task automatic wait_per(input int k);
    while (n_per < k) @(negedge clk);
    #1;
  endtask

  task automatic build_exp(input int n, input int x, input int y, input int z, input bit lm);
    int en;
    en = (n < 2) ? 2 : n;
    exp_cnt = 0;
    if (x == 0 || z == 0) begin
      exp_len[0] = en; exp_fd[0] = 1; exp_cnt = 1;
    end else begin
      for (int g = 0; g < z; g++) begin
        for (int i = 0; i <= x; i++) begin
          if (lm) exp_len[exp_cnt] = (i == 0) ? en : en + 1;
          else    exp_len[exp_cnt] = (i == x) ? en + 1 : en;
          exp_fd[exp_cnt] = 0;
          exp_cnt++;
        end
      end
      for (int t = 0; t < y; t++) begin
        exp_len[exp_cnt] = lm ? en + 1 : en;
        exp_fd[exp_cnt] = 0;
        exp_cnt++;
      end
      exp_fd[exp_cnt-1] = 1;
    end
  endtask

  task automatic cmp_frames(input int base, input int reps, input string req);
    for (int r = 0; r < reps; r++) begin
      for (int i = 0; i < exp_cnt; i++) begin
        int k;
        k = base + r * exp_cnt + i;
        chk(len_log[k] == exp_len[i], req, len_log[k], exp_len[i]);
        chk(hi_log[k] == exp_len[i] / 2, "R6 high time", hi_log[k], exp_len[i] / 2);
        chk(fd_log[k] == exp_fd[i], "R10 frame flag", fd_log[k], exp_fd[i]);
      end
    end
  endtask

  task automatic apply(input int n, input int x, input int y, input int z, input bit lm);
    wr_cfg(n, x, y, z, lm);
    pulse_upd();
    arm_next_frame();
    build_exp(n, x, y, z, lm);
  endtask

  // R1, R2, R7: reset state, default setting, shadow writes held back
  task automatic t_reset_and_shadow();
    rst_n = 1'b0; cap_on = 1'b1; cap_started = 1'b0; n_per = 0; prev_fd = 1'b1;
    repeat (3) @(negedge clk);
    chk(mclk_en == 1'b1, "R1 reset mclk_en", mclk_en, 1);
    chk(mclk_out == 1'b1, "R1 reset mclk_out", mclk_out, 1);
    chk(frame_done == 1'b0, "R1 reset frame_done", frame_done, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(mclk_en == 1'b1, "R1 first cycle mclk_en", mclk_en, 1);
    chk(frame_done == 1'b0, "R1 first cycle frame_done", frame_done, 0);
    wait_per(3);
    wr_cfg(9, 2, 1, 3, 1'b0);
    wait_per(12);
    build_exp(4, 0, 0, 0, 1'b0);
    cmp_frames(0, 12, "R7 R2 default divide by 4");
  endtask

  // R3, R8: short-majority pattern, update waits for the frame end
  task automatic t_mode0_boundary();
    apply(5, 2, 1, 3, 1'b0);
    wait_per(2);
    wr_cfg(3, 0, 0, 0, 1'b0);
    pulse_upd();
    wait_per(14);
    build_exp(5, 2, 1, 3, 1'b0);
    chk(exp_cnt == 10, "R3 pattern size", exp_cnt, 10);
    cmp_frames(0, 1, "R8 R3 old frame completes");
    build_exp(3, 0, 0, 0, 1'b0);
    cmp_frames(10, 4, "R8 new setting after boundary");
  endtask

  // R4, R5: long-majority 24.576 MHz setting
  task automatic t_mode1_example();
    int total;
    longint f;
    apply(6, 1, 2, 47, 1'b1);
    wait_per(2 * 96);
    chk(exp_cnt == 96, "R5 periods per frame", exp_cnt, 96);
    cmp_frames(0, 2, "R4 long-majority pattern");
    total = 0;
    for (int i = 0; i < 96; i++) total += len_log[i];
    chk(total == 625, "R5 cycles per frame", total, 625);
    f = (64'd160000000 * 64'(n_per / 2)) / 64'(total);
    chk(f == 64'd24576000, "R5 average frequency", int'(f), 24576000);
  endtask

  // R2: group count zero disables the fraction
  task automatic t_frac_off();
    apply(5, 3, 4, 0, 1'b0);
    wait_per(8);
    cmp_frames(0, 8, "R2 fraction off");
  endtask

  // R11: no tail with Y zero
  task automatic t_no_tail();
    apply(3, 2, 0, 2, 1'b1);
    wait_per(12);
    chk(exp_cnt == 6, "R11 pattern size", exp_cnt, 6);
    cmp_frames(0, 2, "R11 tailless frame");
  endtask

  // R9: divisors below 2 clamp to 2
  task automatic t_min_div();
    apply(1, 0, 0, 0, 1'b0);
    wait_per(6);
    cmp_frames(0, 6, "R9 divisor 1");
    apply(0, 0, 0, 0, 1'b0);
    wait_per(6);
    cmp_frames(0, 6, "R9 divisor 0");
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cfg_wr = 1'b0; cfg_upd = 1'b0; cfg_long_maj = 1'b0;
    cfg_div_n = '0; cfg_rep_x = '0; cfg_tail_y = '0; cfg_grp_z = '0;
    cap_on = 1'b0; cap_started = 1'b0; prev_fd = 1'b0; n_per = 0;
    cur_len = 0; cur_hi = 0; cur_fd = 0;
    rst_n = 1'b0;
    t_reset_and_shadow();
    t_mode0_boundary();
    t_mode1_example();
    t_frac_off();
    t_no_tail();
    t_min_div();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule